// File: doc/BRIEF.md
# Thermal trip register unit

This block is the register and interrupt front end of an on-chip temperature sensor. Each time the sampling logic fires its strobe, the block latches a fresh temperature code. It pushes the code it held before into a short history of earlier readings. Software reads the latest code, the history, two calibration bytes and a sensor-ready flag through a single-cycle register port.

Trip points are programmed as one base threshold plus a small offset per level. The current code is compared against every level at once. When a level's compare condition goes from false to true, the matching status bit is set. Software masks the status bits with an enable register and clears them by writing ones to a clear register. Status, enable and clear bits sit at bit 0, 4, 8 and 12 for levels 0 to 3. A single level-sensitive interrupt line reports any enabled, pending level. A control word holds the on/off mode and the gain and reference-voltage settings for the analog front end.

Top module: `thermtrip_regs`

## Requirements
- R1: After reset the control word, threshold, offsets, current code, history, enable and status registers all read 0, and `irq` is low.
- R2: Address 0x00 returns `cal_info` in bits [15:0] with zeros above. Address 0x28 returns `sens_ready` in bit 0 with zeros above.
- R3: The control word at 0x20 keeps the mode in bits [1:0], the gain in bits [11:8] and the reference setting in bits [28:24]. All other bits read 0. Sensing is on only when mode equals 3; the value 2 is the off state.
- R4: While sensing is off, `smp_stb` has no effect: the current code and the history keep their values.
- R5: While sensing is on, each strobe loads `smp_code` into the current-code register (0x40). The old current code moves to 0x60, and each history entry moves one place toward 0x6C; the oldest is dropped.
- R6: Level n (0 to 3) hits when the current code is strictly greater than threshold (0x44) plus offset n (0x50 + 4n). Threshold and offsets read back as 8-bit values. The status bit is set whether or not the level is enabled.
- R7: The threshold plus offset sum is formed with one extra bit, so a sum above 255 is never exceeded by any code.
- R8: A status bit is set only on a false-to-true change of its level's hit. A condition that stays true does not set the bit again after a clear.
- R9: Writing 0x78 clears each status bit (0x74, bit 4n) whose data bit 4n is 1. Status bits with a 0 in the written data are left unchanged.
- R10: The enable register (0x70) holds one bit per level at bit 4n; other bits read 0. `irq` is high exactly when some status bit and its enable bit are both set and sensing is on.
- R11: While sensing is off, `irq` is held low and no status bit is set. A level that was already past its trip point when sensing comes back on does not set its status bit.
- R12: Writes to 0x00, 0x28, 0x40, 0x60 to 0x6C and 0x74 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle pulse: new temperature code valid |
| smp_code | input | 8 | Temperature code from the converter |
| cal_info | input | 16 | Two calibration bytes, low byte first |
| sens_ready | input | 1 | Sensor ready flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit codes and offsets, four trip levels and a four-entry history. With 8-bit codes, every code a few steps either side of each trip point can be swept for two threshold settings. One setting places the fourth limit above 255, so the case where the extended sum must not wrap is reached with real codes. The four-level layout lets every nibble position of the enable, status and clear registers be exercised, both singly and together.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;
  // register byte addresses
  localparam int A_CAL   = 'h00;
  localparam int A_CTRL  = 'h20;
  localparam int A_RDY   = 'h28;
  localparam int A_NOW   = 'h40;
  localparam int A_BASE  = 'h44;
  localparam int A_STEP0 = 'h50;
  localparam int A_HIST0 = 'h60;
  localparam int A_IEN   = 'h70;
  localparam int A_IST   = 'h74;
  localparam int A_ICLR  = 'h78;

  // spacing of per-level bits and per-entry registers
  localparam int LANE_STRIDE = 4;
  localparam int WORD_STRIDE = 4;

  // control word layout
  localparam int GAIN_LSB = 8;
  localparam int VREF_LSB = 24;

  localparam logic [1:0] MODE_ON  = 2'b11;
  localparam logic [1:0] MODE_OFF = 2'b10;
endpackage

// File: rtl/tt_sample_hist.sv
module tt_sample_hist #(
  parameter int CODE_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept,
  input  logic [CODE_W-1:0]             code_in,
  output logic [CODE_W-1:0]             code_now,
  output logic [DEPTH-1:0][CODE_W-1:0]  hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_now <= '0;
    else if (accept) code_now <= code_in;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_hist
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hist[0] <= '0;
        else if (accept) hist[0] <= code_now;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hist[i] <= '0;
        else if (accept) hist[i] <= hist[i-1];
      end
    end
  end
endmodule

// File: rtl/tt_trip_cmp.sv
module tt_trip_cmp #(
  parameter int CODE_W = 8,
  parameter int OFS_W  = 8,
  parameter int LEVELS = 4
) (
  input  logic [CODE_W-1:0]             code,
  input  logic [CODE_W-1:0]             base,
  input  logic [LEVELS-1:0][OFS_W-1:0]  ofs,
  output logic [LEVELS-1:0]             hit
);
  localparam int SUM_W = CODE_W + 1;

  // trip limit carried with one extra bit so it never wraps
  function automatic logic [SUM_W-1:0] trip_limit(input logic [CODE_W-1:0] b,
                                                   input logic [OFS_W-1:0]  o);
    return {1'b0, b} + SUM_W'(o);
  endfunction

  for (genvar n = 0; n < LEVELS; n++) begin : g_lvl
    assign hit[n] = ({1'b0, code} > trip_limit(base, ofs[n]));
  end
endmodule

// File: rtl/tt_irq_ctl.sv
module tt_irq_ctl #(
  parameter int LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sens_on,
  input  logic [LEVELS-1:0] hit,
  input  logic [LEVELS-1:0] clr,
  input  logic [LEVELS-1:0] ien,
  output logic [LEVELS-1:0] ist,
  output logic [LEVELS-1:0] rise,
  output logic              irq
);
  logic [LEVELS-1:0] hit_q;
  logic [LEVELS-1:0] set_v;

  assign rise  = hit & ~hit_q;
  assign set_v = rise & {LEVELS{sens_on}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      ist   <= '0;
    end else begin
      hit_q <= hit;
      ist   <= (ist & ~clr) | set_v;
    end
  end

  assign irq = sens_on & (|(ist & ien));
endmodule

// File: rtl/thermtrip_regs.sv
module thermtrip_regs
  import thermtrip_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int OFS_W      = 8,
  parameter int HIST_DEPTH = 4,
  parameter int LEVELS     = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CAL_W      = 16,
  parameter int GAIN_W     = 4,
  parameter int VREF_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [CAL_W-1:0]  cal_info,
  input  logic              sens_ready,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  // ---------------- write decode ----------------
  logic wr_ctrl, wr_base, wr_ien, wr_clr, wr_now;
  logic [LEVELS-1:0] wr_step;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_base = reg_wr && (reg_addr == ADDR_W'(A_BASE));
  assign wr_ien  = reg_wr && (reg_addr == ADDR_W'(A_IEN));
  assign wr_clr  = reg_wr && (reg_addr == ADDR_W'(A_ICLR));
  assign wr_now  = reg_wr && (reg_addr == ADDR_W'(A_NOW));

  for (genvar n = 0; n < LEVELS; n++) begin : g_wstep
    assign wr_step[n] = reg_wr && (reg_addr == ADDR_W'(A_STEP0 + WORD_STRIDE * n));
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  // ---------------- control and trip registers ----------------
  logic [1:0]        mode_q;
  logic [GAIN_W-1:0] gain_q;
  logic [VREF_W-1:0] vref_q;
  logic [CODE_W-1:0] base_q;
  logic [LEVELS-1:0][OFS_W-1:0] step_q;
  logic [LEVELS-1:0] ien_v;
  logic [LEVELS-1:0] clr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      gain_q <= '0;
      vref_q <= '0;
    end else if (wr_ctrl) begin
      mode_q <= reg_wdata[1:0];
      gain_q <= reg_wdata[GAIN_LSB +: GAIN_W];
      vref_q <= reg_wdata[VREF_LSB +: VREF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (wr_base) base_q <= reg_wdata[CODE_W-1:0];
  end

  for (genvar n = 0; n < LEVELS; n++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          step_q[n] <= '0;
      else if (wr_step[n]) step_q[n] <= reg_wdata[OFS_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_v[n] <= 1'b0;
      else if (wr_ien) ien_v[n] <= reg_wdata[LANE_STRIDE * n];
    end
    assign clr_v[n] = wr_clr & reg_wdata[LANE_STRIDE * n];
  end

  logic sens_on, acc_stb;
  assign sens_on = (mode_q == MODE_ON);
  assign acc_stb = smp_stb & sens_on;

  // ---------------- datapath ----------------
  logic [CODE_W-1:0] code_now;
  logic [HIST_DEPTH-1:0][CODE_W-1:0] hist_q;
  logic [LEVELS-1:0] hit_v, ist_v, rise_v;

  tt_sample_hist #(.CODE_W(CODE_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .accept(acc_stb), .code_in(smp_code),
    .code_now(code_now), .hist(hist_q)
  );

  tt_trip_cmp #(.CODE_W(CODE_W), .OFS_W(OFS_W), .LEVELS(LEVELS)) u_cmp (
    .code(code_now), .base(base_q), .ofs(step_q), .hit(hit_v)
  );

  tt_irq_ctl #(.LEVELS(LEVELS)) u_irq (
    .clk(clk), .rst_n(rst_n), .sens_on(sens_on), .hit(hit_v), .clr(clr_v),
    .ien(ien_v), .ist(ist_v), .rise(rise_v), .irq(irq)
  );

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CAL))  reg_rdata[CAL_W-1:0] = cal_info;
    if (reg_addr == ADDR_W'(A_RDY))  reg_rdata[0] = sens_ready;
    if (reg_addr == ADDR_W'(A_CTRL)) begin
      reg_rdata[1:0] = mode_q;
      reg_rdata[GAIN_LSB +: GAIN_W] = gain_q;
      reg_rdata[VREF_LSB +: VREF_W] = vref_q;
    end
    if (reg_addr == ADDR_W'(A_NOW))  reg_rdata[CODE_W-1:0] = code_now;
    if (reg_addr == ADDR_W'(A_BASE)) reg_rdata[CODE_W-1:0] = base_q;
    for (int n = 0; n < LEVELS; n++) begin
      if (reg_addr == ADDR_W'(A_STEP0 + WORD_STRIDE * n))
        reg_rdata[OFS_W-1:0] = step_q[n];
      if (reg_addr == ADDR_W'(A_IEN)) reg_rdata[LANE_STRIDE * n] = ien_v[n];
      if (reg_addr == ADDR_W'(A_IST)) reg_rdata[LANE_STRIDE * n] = ist_v[n];
    end
    for (int i = 0; i < HIST_DEPTH; i++) begin
      if (reg_addr == ADDR_W'(A_HIST0 + WORD_STRIDE * i))
        reg_rdata[CODE_W-1:0] = hist_q[i];
    end
  end
endmodule

// File: rtl/tt_chk.sv
module tt_chk #(
  parameter int CODE_W = 8,
  parameter int LEVELS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sens_on,
  input logic              acc_stb,
  input logic [CODE_W-1:0] code_now,
  input logic [CODE_W-1:0] hist0,
  input logic              wr_now,
  input logic [LEVELS-1:0] ist,
  input logic [LEVELS-1:0] rise,
  input logic [LEVELS-1:0] clr,
  input logic              irq
);
  // R11
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sens_on |-> !irq);

  // R8
  set_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ist & ~$past(ist) & ~$past(rise)) == '0));

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ist & $past(clr & ~rise)) == '0));

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |=> (hist0 == $past(code_now)));

  // R12
  now_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && !acc_stb) |=> $stable(code_now));

  // R4
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sens_on |=> $stable(code_now));
endmodule

bind thermtrip_regs tt_chk #(.CODE_W(CODE_W), .LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sens_on(sens_on), .acc_stb(acc_stb),
  .code_now(code_now), .hist0(hist_q[0]), .wr_now(wr_now), .ist(ist_v),
  .rise(rise_v), .clr(clr_v), .irq(irq)
);

// File: tb/sim_thermtrip_regs.sv
`timescale 1ns/1ps
module sim_thermtrip_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_stb = 1'b0;
  logic [7:0]  smp_code = '0;
  logic [15:0] cal_info = 16'hC3A5;
  logic        sens_ready = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  thermtrip_regs u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_code(smp_code),
    .cal_info(cal_info), .sens_ready(sens_ready), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic strobe(input logic [7:0] c);
    @(negedge clk);
    smp_stb = 1'b1; smp_code = c;
    @(negedge clk);
    smp_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    #1;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  function automatic logic [31:0] exp_ist(input int c, input int b, input int o0,
                                          input int o1, input int o2, input int o3);
    logic [31:0] m = '0;
    if (c > b + o0) m[0]  = 1'b1;
    if (c > b + o1) m[4]  = 1'b1;
    if (c > b + o2) m[8]  = 1'b1;
    if (c > b + o3) m[12] = 1'b1;
    return m;
  endfunction

  task automatic sweep(input int b, input int o0, input int o1, input int o2,
                       input int o3, input int lo, input int hi, input string tag);
    wr(8'h44, 32'(b));
    wr(8'h50, 32'(o0)); wr(8'h54, 32'(o1)); wr(8'h58, 32'(o2)); wr(8'h5C, 32'(o3));
    rd_chk(8'h44, 32'(b), tag);
    rd_chk(8'h5C, 32'(o3), tag);
    for (int c = lo; c <= hi; c++) begin
      strobe(8'h00);
      wr(8'h78, 32'h1111);
      strobe(8'(c));
      rd_chk(8'h74, exp_ist(c, b, o0, o1, o2, o3), tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(8'h20, 32'h0, "R1 ctrl");
    rd_chk(8'h40, 32'h0, "R1 now");
    rd_chk(8'h44, 32'h0, "R1 base");
    rd_chk(8'h60, 32'h0, "R1 hist");
    rd_chk(8'h70, 32'h0, "R1 ien");
    rd_chk(8'h74, 32'h0, "R1 ist");
    irq_chk(1'b0, "R1");

    // R2 calibration and ready
    rd_chk(8'h00, 32'h0000C3A5, "R2 cal");
    rd_chk(8'h28, 32'h0, "R2 not ready");
    sens_ready = 1'b1;
    rd_chk(8'h28, 32'h1, "R2 ready");

    // R4 strobe ignored while off
    strobe(8'h77);
    rd_chk(8'h40, 32'h0, "R4 now");

    // R3 control fields
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk(8'h20, 32'h1F00_0F03, "R3 mask");
    wr(8'h20, 32'h0A00_0503);
    rd_chk(8'h20, 32'h0A00_0503, "R3 on");

    // R5 history shift
    strobe(8'd11); strobe(8'd22); strobe(8'd33); strobe(8'd44); strobe(8'd55);
    rd_chk(8'h40, 32'd55, "R5 now");
    rd_chk(8'h60, 32'd44, "R5 h0");
    rd_chk(8'h64, 32'd33, "R5 h1");
    rd_chk(8'h68, 32'd22, "R5 h2");
    rd_chk(8'h6C, 32'd11, "R5 h3");

    // R6 compare sweep, enables off
    sweep(100, 0, 5, 10, 20, 90, 135, "R6");
    wr(8'h50, 32'h1FF);
    rd_chk(8'h50, 32'hFF, "R6 ofs width");
    // R7 sum above 255 never reached
    sweep(250, 0, 3, 5, 20, 240, 255, "R7");

    // R8 edge-only status
    sweep(100, 0, 5, 10, 20, 130, 130, "R8 setup");
    wr(8'h78, 32'h1111);
    @(negedge clk);
    rd_chk(8'h74, 32'h0, "R8 held level");
    strobe(8'd131);
    rd_chk(8'h74, 32'h0, "R8 no rise");

    // R9 selective clear
    strobe(8'd0);
    strobe(8'd130);
    rd_chk(8'h74, 32'h1111, "R9 all set");
    wr(8'h78, 32'h0010);
    rd_chk(8'h74, 32'h1101, "R9 one cleared");

    // R10 enable masking
    wr(8'h70, 32'hFFFF_FFFF);
    rd_chk(8'h70, 32'h1111, "R10 ien mask");
    wr(8'h70, 32'h0100);
    irq_chk(1'b1, "R10 lvl2");
    wr(8'h78, 32'h0100);
    irq_chk(1'b0, "R10 cleared");
    rd_chk(8'h74, 32'h1001, "R10 ist");
    wr(8'h70, 32'h0010);
    irq_chk(1'b0, "R10 lvl1 no status");
    wr(8'h70, 32'h1000);
    irq_chk(1'b1, "R10 lvl3");

    // R11 off state
    wr(8'h20, 32'h2);
    irq_chk(1'b0, "R11 off irq");
    wr(8'h78, 32'h1111);
    wr(8'h20, 32'h3);
    wr(8'h44, 32'd200);
    wr(8'h20, 32'h2);
    wr(8'h44, 32'd100);
    @(negedge clk);
    rd_chk(8'h74, 32'h0, "R11 no set while off");
    wr(8'h20, 32'h3);
    @(negedge clk);
    rd_chk(8'h74, 32'h0, "R11 no set on resume");
    irq_chk(1'b0, "R11 resume irq");

    // R12 read-only writes
    wr(8'h40, 32'h5A);
    rd_chk(8'h40, 32'd130, "R12 now");
    wr(8'h00, 32'h0);
    rd_chk(8'h00, 32'h0000C3A5, "R12 cal");
    wr(8'h28, 32'h0);
    rd_chk(8'h28, 32'h1, "R12 ready");
    wr(8'h60, 32'hFF);
    rd_chk(8'h60, 32'd0, "R12 hist");
    wr(8'h74, 32'hFFFF);
    rd_chk(8'h74, 32'h0, "R12 ist");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule